// File: doc/BRIEF.md
# Region-Based Stride Prefetch Engine

This engine watches the data-side demand load addresses of a processor and produces prefetch requests ahead of them, so that part of the memory latency is hidden behind useful work. Software describes up to four address windows. Each window has an inclusive lower bound, an inclusive upper bound, a step size and an enable flag, written through a simple register-write port. Prefetching happens only inside these windows. Accesses outside every enabled window are ignored.

When a demand access lands in an enabled window, the engine adds that window's step to the demand address and rounds the sum down to a 64-byte line. It drops the candidate if the sum leaves the window, if the sum overflows 32 bits, or if the line repeats the last line queued for that window. Surviving candidates enter a four-entry request queue. A consumer drains the queue through a valid/ready port. When the queue is full, candidates are dropped, so the demand stream never stalls.

Top module: `stride_prefetch_engine`

## Requirements
- R1: After an active-low synchronous reset every window is disabled, every window's step is zero and `pf_valid` is low.
- R2: A demand address hits a window only when that window is enabled (field code 3, bit 0 of the write data) and lower bound (field code 0) <= address <= upper bound (field code 1), compared as unsigned 32-bit values.
- R3: When several enabled windows hold the address, the one with the smallest index is used, and no other window is consulted.
- R4: The requested address is the demand address plus the chosen window's step (field code 2), with its low 6 bits cleared.
- R5: No request is made when the unrounded sum exceeds the window's upper bound, or when the addition carries past 2^32.
- R6: A window whose step is zero produces no requests.
- R7: A candidate is dropped when its line equals the last line queued for the same window.
- R8: Any register write to a window forgets that window's last queued line. The lookup in the cycle of the write uses the values from before the write. If a request from that window is queued in the same cycle, the write's clearing takes priority.
- R9: With an empty queue, a request appears on `pf_valid`/`pf_addr` immediately after the clock edge that samples the demand.
- R10: Requests leave in arrival order from a four-entry queue. When the queue is full and nothing is popped in that cycle, the candidate is dropped and the window's last line is not updated. When the queue is full and an entry is popped in the same cycle, the candidate is accepted.
- R11: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_region | input | 2 | Window index for the write |
| cfg_field | input | 2 | 0 lower bound, 1 upper bound, 2 step, 3 enable |
| cfg_wdata | input | 32 | Write data |
| dmd_valid | input | 1 | Demand access present |
| dmd_addr | input | 32 | Demand byte address |
| pf_valid | output | 1 | Prefetch request available |
| pf_addr | output | 32 | Line-aligned prefetch address |
| pf_ready | input | 1 | Consumer accepts the request |

## Verification
Two pairs of events can fall in one cycle. The first pair is a pop and a push against a full queue. The bench holds `pf_ready` low until four requests are queued, then raises it in the same cycle as a new demand, and expects the newcomer to be queued behind the survivors. The second pair is a register write and a queued request for the same window. The bench rewrites a window on the very cycle a demand hits it, then repeats that demand and expects the line to be issued again. A queue model in the bench, fed with the same random and directed stimulus, judges every cycle.

// File: rtl/spe_pkg.sv
package spe_pkg;
   typedef enum logic [1:0] {
      FLD_LOWER  = 2'd0,
      FLD_UPPER  = 2'd1,
      FLD_STEP   = 2'd2,
      FLD_ENABLE = 2'd3
   } spe_field_e;
endpackage

// File: rtl/spe_region_file.sv
module spe_region_file #(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGIONS = 4,
   parameter int LINE_W      = 26,
   parameter int RIDX_W      = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cfg_we,
   input  logic [RIDX_W-1:0]                     cfg_region,
   input  logic [1:0]                            cfg_field,
   input  logic [ADDR_W-1:0]                     cfg_wdata,
   input  logic                                  upd_en,
   input  logic [RIDX_W-1:0]                     upd_region,
   input  logic [LINE_W-1:0]                     upd_line,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    r_lower,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    r_upper,
   output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    r_step,
   output logic [NUM_REGIONS-1:0]                r_en,
   output logic [NUM_REGIONS-1:0][LINE_W-1:0]    r_last,
   output logic [NUM_REGIONS-1:0]                r_last_vld
);
   import spe_pkg::*;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
      logic wr_hit;
      logic upd_hit;
      assign wr_hit  = cfg_we && (cfg_region == RIDX_W'(g));
      assign upd_hit = upd_en && (upd_region == RIDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r_lower[g]    <= '0;
            r_upper[g]    <= '0;
            r_step[g]     <= '0;
            r_en[g]       <= 1'b0;
            r_last[g]     <= '0;
            r_last_vld[g] <= 1'b0;
         end else begin
            if (wr_hit) begin
               unique case (spe_field_e'(cfg_field))
                  FLD_LOWER:  r_lower[g] <= cfg_wdata;
                  FLD_UPPER:  r_upper[g] <= cfg_wdata;
                  FLD_STEP:   r_step[g]  <= cfg_wdata;
                  FLD_ENABLE: r_en[g]    <= cfg_wdata[0];
               endcase
            end
            // a write forgets the record, even against a same-cycle push
            if (wr_hit) begin
               r_last_vld[g] <= 1'b0;
            end else if (upd_hit) begin
               r_last_vld[g] <= 1'b1;
               r_last[g]     <= upd_line;
            end
         end
      end
   end
endmodule

// File: rtl/spe_region_match.sv
module spe_region_match #(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGIONS = 4,
   parameter int LINE_LSB    = 6,
   parameter int RIDX_W      = 2,
   localparam int LINE_W     = ADDR_W - LINE_LSB
) (
   input  logic                               dmd_valid,
   input  logic [ADDR_W-1:0]                  dmd_addr,
   input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] r_lower,
   input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] r_upper,
   input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] r_step,
   input  logic [NUM_REGIONS-1:0]             r_en,
   input  logic [NUM_REGIONS-1:0][LINE_W-1:0] r_last,
   input  logic [NUM_REGIONS-1:0]             r_last_vld,
   output logic                               cand_valid,
   output logic [RIDX_W-1:0]                  cand_region,
   output logic [LINE_W-1:0]                  cand_line
);
   logic [NUM_REGIONS-1:0] hit_vec;
   logic                   any_hit;
   logic [ADDR_W:0]        next_sum;
   logic                   in_bounds;
   logic                   repeat_line;
   logic                   step_zero;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
      assign hit_vec[g] = r_en[g] && (dmd_addr >= r_lower[g]) && (dmd_addr <= r_upper[g]);
   end

   // lowest index wins: scan downward so the last assignment is the smallest
   always_comb begin
      cand_region = '0;
      any_hit     = 1'b0;
      for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            cand_region = RIDX_W'(i);
            any_hit     = 1'b1;
         end
      end
   end

   assign next_sum    = {1'b0, dmd_addr} + {1'b0, r_step[cand_region]};
   assign step_zero   = (r_step[cand_region] == '0);
   assign in_bounds   = !next_sum[ADDR_W] && (next_sum[ADDR_W-1:0] <= r_upper[cand_region]);
   assign cand_line   = next_sum[ADDR_W-1:LINE_LSB];
   assign repeat_line = r_last_vld[cand_region] && (r_last[cand_region] == cand_line);
   assign cand_valid  = dmd_valid && any_hit && !step_zero && in_bounds && !repeat_line;
endmodule

// File: rtl/spe_req_fifo.sv
module spe_req_fifo #(
   parameter int WIDTH  = 26,
   parameter int DEPTH  = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic             accepted,
   output logic             out_valid,
   output logic [WIDTH-1:0] rdata,
   output logic [CNT_W-1:0] count
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             full, do_pop;

   assign full      = (count == CNT_W'(DEPTH));
   assign out_valid = (count != '0);
   assign do_pop    = pop && out_valid;
   assign accepted  = push && (!full || do_pop);
   assign rdata     = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (accepted) begin
            mem[wr_ptr] <= wdata;
            wr_ptr      <= bump(wr_ptr);
         end
         if (do_pop) rd_ptr <= bump(rd_ptr);
         unique case ({accepted, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/stride_prefetch_engine.sv
module stride_prefetch_engine #(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGIONS = 4,
   parameter int LINE_BYTES  = 64,
   parameter int FIFO_DEPTH  = 4,
   localparam int LINE_LSB   = $clog2(LINE_BYTES),
   localparam int LINE_W     = ADDR_W - LINE_LSB,
   localparam int RIDX_W     = $clog2(NUM_REGIONS),
   localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [RIDX_W-1:0] cfg_region,
   input  logic [1:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              dmd_valid,
   input  logic [ADDR_W-1:0] dmd_addr,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   input  logic              pf_ready
);
   if ((1 << LINE_LSB) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (NUM_REGIONS < 2) begin : g_bad_regions
      $error("NUM_REGIONS must be at least 2");
   end
   if (FIFO_DEPTH < 1) begin : g_bad_depth
      $error("FIFO_DEPTH must be at least 1");
   end
   if (LINE_LSB < 1 || LINE_LSB >= ADDR_W) begin : g_bad_width
      $error("line size does not fit the address width");
   end

   logic [NUM_REGIONS-1:0][ADDR_W-1:0] r_lower, r_upper, r_step;
   logic [NUM_REGIONS-1:0]             r_en, r_last_vld;
   logic [NUM_REGIONS-1:0][LINE_W-1:0] r_last;
   logic                               cand_valid;
   logic [RIDX_W-1:0]                  cand_region;
   logic [LINE_W-1:0]                  cand_line;
   logic                               q_push;
   logic [LINE_W-1:0]                  head_line;
   logic [CNT_W-1:0]                   q_count;

   spe_region_file #(
      .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .LINE_W(LINE_W), .RIDX_W(RIDX_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
      .upd_en(q_push), .upd_region(cand_region), .upd_line(cand_line),
      .r_lower(r_lower), .r_upper(r_upper), .r_step(r_step), .r_en(r_en),
      .r_last(r_last), .r_last_vld(r_last_vld)
   );

   spe_region_match #(
      .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .LINE_LSB(LINE_LSB), .RIDX_W(RIDX_W)
   ) i_match (
      .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
      .r_lower(r_lower), .r_upper(r_upper), .r_step(r_step), .r_en(r_en),
      .r_last(r_last), .r_last_vld(r_last_vld),
      .cand_valid(cand_valid), .cand_region(cand_region), .cand_line(cand_line)
   );

   spe_req_fifo #(
      .WIDTH(LINE_W), .DEPTH(FIFO_DEPTH)
   ) i_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(cand_valid), .wdata(cand_line), .pop(pf_ready),
      .accepted(q_push), .out_valid(pf_valid), .rdata(head_line), .count(q_count)
   );

   assign pf_addr = {head_line, {LINE_LSB{1'b0}}};
endmodule

// File: rtl/spe_checker.sv
module spe_checker #(
   parameter int ADDR_W   = 32,
   parameter int LINE_LSB = 6,
   parameter int CNT_W    = 3,
   parameter int DEPTH    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pf_valid,
   input logic              pf_ready,
   input logic [ADDR_W-1:0] pf_addr,
   input logic              q_push,
   input logic [CNT_W-1:0]  q_count
);
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) == 1'b0) |-> !pf_valid);

   p_line_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> (pf_addr[LINE_LSB-1:0] == '0));

   p_push_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |=> pf_valid);

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CNT_W'(DEPTH));

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));
endmodule

bind stride_prefetch_engine spe_checker #(
   .ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)
) i_spe_chk (
   .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_ready(pf_ready),
   .pf_addr(pf_addr), .q_push(q_push), .q_count(q_count)
);

// File: tb/test_stride_prefetch_engine.sv
module test_stride_prefetch_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_region = '0;
   logic [1:0]  cfg_field = '0;
   logic [31:0] cfg_wdata = '0;
   logic        dmd_valid = 1'b0;
   logic [31:0] dmd_addr = '0;
   logic        pf_valid;
   logic [31:0] pf_addr;
   logic        pf_ready = 1'b0;

   int total = 0;
   int bad   = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   stride_prefetch_engine i_stride_prefetch_engine (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
      .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
      .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
   );

   // reference model
   logic [31:0] m_lo [4];
   logic [31:0] m_hi [4];
   logic [31:0] m_st [4];
   bit          m_en [4];
   logic [25:0] m_last [4];
   bit          m_lv [4];
   logic [31:0] mq [$];

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         m_lo[i] = '0; m_hi[i] = '0; m_st[i] = '0;
         m_en[i] = 0; m_last[i] = '0; m_lv[i] = 0;
      end
      mq.delete();
   endtask

   function automatic bit predict(input logic [31:0] a, output int r, output logic [25:0] line);
      logic [32:0] s;
      r = -1;
      line = '0;
      for (int i = 3; i >= 0; i--)
         if (m_en[i] && a >= m_lo[i] && a <= m_hi[i]) r = i;
      if (r < 0) return 0;
      if (m_st[r] == 0) return 0;
      s = {1'b0, a} + {1'b0, m_st[r]};
      if (s[32] || s[31:0] > m_hi[r]) return 0;
      line = s[31:6];
      if (m_lv[r] && m_last[r] == line) return 0;
      return 1;
   endfunction

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input bit we, input int rg, input int fld, input logic [31:0] d,
                      input bit dv, input logic [31:0] da, input bit rdy);
      int r;
      logic [25:0] line;
      bit cand, pop;
      int sz;
      @(negedge clk);
      if (mq.size() == 0)
         check(pf_valid == 1'b0, "pf_valid idle", {31'b0, pf_valid}, 32'd0);
      else begin
         check(pf_valid == 1'b1, "pf_valid pending", {31'b0, pf_valid}, 32'd1);
         check(pf_addr == mq[0], "pf_addr head", pf_addr, mq[0]);
      end
      cfg_we = we; cfg_region = 2'(rg); cfg_field = 2'(fld); cfg_wdata = d;
      dmd_valid = dv; dmd_addr = da; pf_ready = rdy;
      @(posedge clk);
      cand = dv && predict(da, r, line);
      sz   = mq.size();
      pop  = (sz > 0) && rdy;
      if (pop) void'(mq.pop_front());
      if (cand && (sz < 4 || pop)) begin
         mq.push_back({line, 6'b0});
         m_last[r] = line;
         m_lv[r]   = 1;
      end
      if (we) begin
         case (fld)
            0: m_lo[rg] = d;
            1: m_hi[rg] = d;
            2: m_st[rg] = d;
            default: m_en[rg] = d[0];
         endcase
         m_lv[rg] = 0;
      end
   endtask

   task automatic wr(input int rg, input int fld, input logic [31:0] d);
      cyc(1, rg, fld, d, 0, '0, 1);
   endtask

   task automatic dm(input logic [31:0] a, input bit rdy);
      cyc(0, 0, 0, '0, 1, a, rdy);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, '0, 1);
   endtask

   task automatic setup(input int rg, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [31:0] st);
      wr(rg, 0, lo); wr(rg, 1, hi); wr(rg, 2, st); wr(rg, 3, 32'd1);
   endtask

   initial begin
      #(200000 * 8);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      model_reset();
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(pf_valid == 1'b0, "pf_valid in reset", {31'b0, pf_valid}, 32'd0);
      rst_n = 1'b1;
      tag = "R1"; idle(2);
      dm(32'h0000_1010, 1); idle(2);   // no window enabled

      // R2 / R4 / R9: basic hit, one step ahead, line aligned, seen next cycle
      tag = "R2"; setup(0, 32'h0000_1000, 32'h0000_1FFF, 32'h0000_0040);
      dm(32'h0000_0FFF, 1);            // below lower bound
      tag = "R9"; dm(32'h0000_1010, 1);
      tag = "R4"; idle(1); dm(32'h0000_1234, 1); idle(1);
      tag = "R2"; dm(32'h0000_1FFF, 1); dm(32'h0000_2000, 1); idle(1);

      // R7: repeat line suppressed
      tag = "R7"; dm(32'h0000_1500, 1); dm(32'h0000_1508, 1); dm(32'h0000_1510, 1); idle(2);

      // R5: upper bound and 32-bit carry
      tag = "R5"; dm(32'h0000_1FF0, 1); dm(32'h0000_1FC0, 1); idle(1);
      setup(3, 32'hF000_0000, 32'hFFFF_FFFF, 32'h2000_0000);
      dm(32'hF800_0000, 1); idle(1);
      wr(3, 2, 32'h0000_0100); dm(32'hFFFF_FE00, 1); dm(32'hFFFF_FF00, 1); idle(2);

      // R3: overlap, lowest index wins
      tag = "R3"; setup(1, 32'h0000_1000, 32'h0000_3000, 32'h0000_0100);
      dm(32'h0000_1100, 1); dm(32'h0000_2100, 1); idle(2);

      // R6: zero step
      tag = "R6"; setup(2, 32'h0000_8000, 32'h0000_9000, 32'h0);
      dm(32'h0000_8100, 1); dm(32'h0000_8200, 1); idle(2);

      // R8: write forgets the record; write and push in same cycle
      tag = "R8"; dm(32'h0000_1600, 1); dm(32'h0000_1600, 1);
      wr(0, 2, 32'h0000_0040); dm(32'h0000_1600, 1);
      cyc(1, 0, 0, 32'h0000_1000, 1, 32'h0000_1700, 1);
      dm(32'h0000_1700, 1); idle(2);

      // R10 / R11: fill the queue, drop when full, pop+push together
      tag = "R11";
      dm(32'h0000_1100, 0); dm(32'h0000_1200, 0); dm(32'h0000_1300, 0); dm(32'h0000_1400, 0);
      tag = "R10"; dm(32'h0000_1800, 0); cyc(0, 0, 0, '0, 0, '0, 0);
      dm(32'h0000_1900, 1); idle(6);

      // random phase
      tag = "R2";
      for (int n = 0; n < 4000; n++) begin
         int k;
         logic [31:0] d, a;
         k = int'($urandom % 32);
         if (k == 0) begin
            int f, rg;
            f = int'($urandom % 4); rg = int'($urandom % 4);
            case (f)
               0: d = $urandom & 32'h0000_7F00;
               1: d = ($urandom & 32'h0000_FFFF);
               2: begin
                  int s;
                  s = int'($urandom % 5);
                  d = (s == 0) ? 32'h0 : (s == 1) ? 32'h40 : (s == 2) ? 32'h80 :
                      (s == 3) ? 32'h400 : ($urandom & 32'h0000_0FFF);
               end
               default: d = {31'b0, 1'(($urandom % 4) != 0)};
            endcase
            cyc(1, rg, f, d, $urandom % 2 == 0, $urandom & 32'h0000_FFFF, $urandom % 3 != 0);
         end else begin
            a = (k == 1) ? $urandom : ($urandom & 32'h0000_FFFF);
            tag = (k % 4 == 0) ? "R10" : "R2";
            cyc(0, 0, 0, '0, $urandom % 4 != 0, a, $urandom % 3 != 0);
         end
      end
      tag = "R10"; idle(8);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule